// File: doc/BRIEF.md
# Four-Bank Interleaved Line-Read Memory Controller

This block sits below a cache and serves its line fills from four memory banks, each one word wide. Word address bits [1:0] select the bank and the remaining upper bits select the row inside that bank, so the four words of a line sit in four different banks. When the cache requests a line, the controller spends an address phase sending one row address to every bank. It starts all four banks together, waits one bank access time, and then hands the words back one by one over a shared one-word bus. Each bank carries its own cycle-accurate access-time counter and drives a ready strobe when its access is finished.

A parameter selects a sequential mode for comparison. In that mode, each word of the line pays its own address phase, access time and transfer. The cache can also store a single word. A store uses only the bank named by the address and takes one address phase, one access time and one transfer window. With the default timings (4-cycle address phase, 24-cycle access, 4-cycle transfer), a line takes 44 cycles interleaved and 128 cycles sequential. A store takes 32 cycles.

Top module: `ilv_line_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `req_ready` is 1 and both `rd_valid` and `wr_done` are 0.
- R2: In interleaved mode, the read request is accepted on a clock edge E0 (`req_valid` and `req_ready` both high). Word k then has `rd_valid` high for exactly one cycle, in the cycle that follows edge E0+T_ADDR+T_ACC+T_XFER*(k+1)-1. With the defaults, those edges are E31, E35, E39 and E43.
- R3: Read words come back in bank order 0,1,2,3. `rd_word` carries the bank number, and `rd_data` carries the word stored at word address row*4+bank.
- R4: `req_ready` is 0 from the acceptance edge until the edge after the last word's valid cycle, and then it returns to 1. While `req_ready` is 0, any `req_valid` has no effect on timing or on stored data.
- R5: With INTERLEAVED=0, word k of a line is valid in the cycle after edge E0+(T_ADDR+T_ACC+T_XFER)*(k+1)-1. With the defaults, a line ends at edge 128. Only one bank is ever started at a time.
- R6: A write (`req_write`=1) stores `req_wdata` only at word address `req_addr`, in both modes. `wr_done` is high for one cycle, after edge E0+T_ADDR+T_ACC+T_XFER-1, and `req_ready` returns on the next edge.
- R7: For a read, address bits [1:0] are ignored: the whole line holding `req_addr` is returned, starting with bank 0.
- R8: `rd_valid` and `wr_done` are never high in the same cycle. A write produces no `rd_valid`, and a read produces no `wr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = single-word store, 0 = line read |
| req_addr | input | ADDR_W | Word address; bits [1:0] select the bank |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Controller idle; a request is accepted on this edge |
| rd_valid | output | 1 | One-cycle strobe: the read word is on `rd_data` |
| rd_word | output | 2 | Bank number of the word being returned |
| rd_data | output | DATA_W | Returned word |
| wr_done | output | 1 | One-cycle strobe: the store has finished |

## Verification
On every cycle, the bound checker tracks the time since acceptance with a counter. It uses that count to check that every read strobe and every store strobe lands on its exact edge in the selected mode. It also checks that words follow bank order, that ready stays low while a transfer is in progress, that the two strobes never overlap, and that only one bank starts at a time in sequential mode. Data correctness can only be shown by the bench scenarios. These cover store isolation from neighbouring words, whole-line return regardless of the low address bits, and requests that arrive while the controller is busy and must leave memory untouched.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int NBANK  = 4;
    localparam int BANK_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACC,
        ST_XFER
    } ilv_state_e;

    typedef struct packed {
        logic              wr;
        logic [BANK_W-1:0] word;
    } ilv_job_t;

    function automatic logic [NBANK-1:0] bank_onehot(input logic [BANK_W-1:0] b);
        logic [NBANK-1:0] m;
        m = '0;
        m[b] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
    parameter int DATA_W = 32,
    parameter int ROWS   = 16,
    parameter int T_ACC  = 24,
    localparam int ROW_W = $clog2(ROWS),
    localparam int CW    = $clog2(T_ACC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic              rdy,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] mem [ROWS];
    logic              busy;
    logic [CW-1:0]     cnt;
    logic              we_q;
    logic [ROW_W-1:0]  row_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            we_q    <= 1'b0;
            row_q   <= '0;
            wdata_q <= '0;
            dout    <= '0;
            for (int i = 0; i < ROWS; i++) mem[i] <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            cnt     <= CW'(T_ACC - 1);
            we_q    <= we;
            row_q   <= row;
            wdata_q <= wdata;
        end else if (busy) begin
            if (cnt == '0) begin
                busy <= 1'b0;
                if (we_q) mem[row_q] <= wdata_q;
                else      dout       <= mem[row_q];
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign rdy = busy && (cnt == '0);
endmodule

// File: rtl/ilv_seq.sv
module ilv_seq
    import ilv_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ROW_W       = 4,
    parameter int T_ADDR      = 4,
    parameter int T_XFER      = 4,
    parameter bit INTERLEAVED = 1'b1,
    localparam int TMAX       = (T_ADDR > T_XFER) ? T_ADDR : T_XFER,
    localparam int CW         = $clog2(TMAX + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              any_rdy,
    output logic              ready,
    output logic [NBANK-1:0]  start,
    output logic              we,
    output logic [ROW_W-1:0]  row,
    output logic [DATA_W-1:0] wdata,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_word,
    output logic              wr_done
);
    ilv_state_e state;
    logic [CW-1:0] cnt;
    ilv_job_t      job;
    logic          addr_last, xfer_last;

    assign addr_last = (state == ST_ADDR) && (cnt == CW'(T_ADDR - 1));
    assign xfer_last = (state == ST_XFER) && (cnt == CW'(T_XFER - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            job   <= '0;
            row   <= '0;
            wdata <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state    <= ST_ADDR;
                    cnt      <= '0;
                    job.wr   <= req_write;
                    job.word <= req_write ? req_bank : '0;
                    row      <= req_row;
                    wdata    <= req_wdata;
                end
                ST_ADDR: begin
                    if (addr_last) begin
                        state <= ST_ACC;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ACC: if (any_rdy) begin
                    state <= ST_XFER;
                    cnt   <= '0;
                end
                default: begin
                    if (xfer_last) begin
                        cnt <= '0;
                        if (job.wr || job.word == BANK_W'(NBANK - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            job.word <= job.word + 1'b1;
                            state    <= INTERLEAVED ? ST_XFER : ST_ADDR;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    always_comb begin
        start = '0;
        if (addr_last) begin
            if (INTERLEAVED && !job.wr) start = '1;
            else                        start = bank_onehot(job.word);
        end
    end

    assign ready    = (state == ST_IDLE);
    assign we       = job.wr;
    assign rd_valid = xfer_last && !job.wr;
    assign wr_done  = xfer_last && job.wr;
    assign rd_word  = job.word;
endmodule

// File: rtl/ilv_line_ctrl.sv
module ilv_line_ctrl
    import ilv_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ROWS        = 16,
    parameter int T_ADDR      = 4,
    parameter int T_ACC       = 24,
    parameter int T_XFER      = 4,
    parameter bit INTERLEAVED = 1'b1,
    localparam int ROW_W      = $clog2(ROWS),
    localparam int ADDR_W     = ROW_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_done
);
    logic [NBANK-1:0]  bank_start;
    logic [NBANK-1:0]  bank_rdy;
    logic [DATA_W-1:0] bank_dout [NBANK];
    logic              bus_we;
    logic [ROW_W-1:0]  bus_row;
    logic [DATA_W-1:0] bus_wdata;

    ilv_seq #(
        .DATA_W(DATA_W), .ROW_W(ROW_W), .T_ADDR(T_ADDR),
        .T_XFER(T_XFER), .INTERLEAVED(INTERLEAVED)
    ) u_seq (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_addr[BANK_W-1:0]), .req_row(req_addr[ADDR_W-1:BANK_W]),
        .req_wdata(req_wdata), .any_rdy(|bank_rdy),
        .ready(req_ready), .start(bank_start), .we(bus_we),
        .row(bus_row), .wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_word(rd_word), .wr_done(wr_done)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        ilv_bank #(.DATA_W(DATA_W), .ROWS(ROWS), .T_ACC(T_ACC)) u_bank (
            .clk(clk), .rst(rst), .start(bank_start[b]), .we(bus_we),
            .row(bus_row), .wdata(bus_wdata),
            .rdy(bank_rdy[b]), .dout(bank_dout[b])
        );
    end

    assign rd_data = bank_dout[rd_word];
endmodule

// File: rtl/ilv_chk.sv
module ilv_chk
    import ilv_pkg::*;
#(
    parameter int T_ADDR      = 4,
    parameter int T_ACC       = 24,
    parameter int T_XFER      = 4,
    parameter bit INTERLEAVED = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [BANK_W-1:0] rd_word,
    input logic              wr_done,
    input logic [NBANK-1:0]  bank_start
);
    logic [15:0]       since;
    logic [BANK_W-1:0] last_w;

    function automatic int due(input logic [BANK_W-1:0] k);
        if (INTERLEAVED) return T_ADDR + T_ACC + T_XFER * (int'(k) + 1) - 1;
        return (T_ADDR + T_ACC + T_XFER) * (int'(k) + 1) - 1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            since  <= '0;
            last_w <= '0;
        end else begin
            if (req_valid && req_ready) since <= '0;
            else if (since != 16'hFFFF) since <= since + 1'b1;
            if (rd_valid) last_w <= rd_word;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> req_ready && !rd_valid && !wr_done); // R1
    AST_READ_DUE: assert property (@(posedge clk) disable iff (rst) rd_valid |-> int'(since) == due(rd_word)); // R2
    AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid); // R2
    AST_WORD_ORDER: assert property (@(posedge clk) disable iff (rst) (rd_valid && rd_word != '0) |-> rd_word == last_w + 1'b1); // R3
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) (rd_valid || wr_done) |-> !req_ready); // R4
    AST_LAST_FREES: assert property (@(posedge clk) disable iff (rst) (rd_valid && rd_word == BANK_W'(NBANK - 1)) |=> req_ready); // R4
    AST_ONE_BANK_SEQ: assert property (@(posedge clk) disable iff (rst) !INTERLEAVED |-> $onehot0(bank_start)); // R5
    AST_WRITE_DUE: assert property (@(posedge clk) disable iff (rst) wr_done |-> int'(since) == T_ADDR + T_ACC + T_XFER - 1); // R6
    AST_WRITE_FREES: assert property (@(posedge clk) disable iff (rst) wr_done |=> req_ready); // R6
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst) !(rd_valid && wr_done)); // R8
endmodule

bind ilv_line_ctrl ilv_chk #(
    .T_ADDR(T_ADDR), .T_ACC(T_ACC), .T_XFER(T_XFER), .INTERLEAVED(INTERLEAVED)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_word(rd_word), .wr_done(wr_done),
    .bank_start(bank_start)
);

// File: tb/tb_ilv_line_ctrl.sv
module tb_ilv_line_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TA = 4, TC = 24, TX = 4;
    localparam int DW = 32, AW = 6, NW = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] req_v = '0;
    logic req_wr = 1'b0;
    logic [AW-1:0] req_a = '0;
    logic [DW-1:0] req_d = '0;
    logic rdy0, v0, wd0, rdy1, v1, wd1;
    logic [1:0] w0, w1;
    logic [DW-1:0] d0, d1;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    logic [DW-1:0] model [NW];

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_line_ctrl #(.INTERLEAVED(1'b1)) dut (
        .clk(clk), .rst(rst), .req_valid(req_v[0]), .req_write(req_wr),
        .req_addr(req_a), .req_wdata(req_d), .req_ready(rdy0),
        .rd_valid(v0), .rd_word(w0), .rd_data(d0), .wr_done(wd0));

    ilv_line_ctrl #(.INTERLEAVED(1'b0)) dut_seq (
        .clk(clk), .rst(rst), .req_valid(req_v[1]), .req_write(req_wr),
        .req_addr(req_a), .req_wdata(req_d), .req_ready(rdy1),
        .rd_valid(v1), .rd_word(w1), .rd_data(d1), .wr_done(wd1));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_cycle(input int which, input int k);
        if (which == 0) return TA + TC + TX * (k + 1) - 1;
        return (TA + TC + TX) * (k + 1) - 1;
    endfunction

    task automatic do_write(input int which, input int a, input logic [DW-1:0] d);
        int seen = 0, rseen = 0;
        @(negedge clk);
        chk((which ? rdy1 : rdy0) == 1'b1, "R4", "ready before write", 0, 1);
        req_v[which] = 1'b1; req_wr = 1'b1; req_a = AW'(a); req_d = d;
        @(posedge clk);
        for (int n = 0; n <= TA + TC + TX; n++) begin
            @(negedge clk);
            if (n == 0) req_v[which] = 1'b0;
            if (which ? wd1 : wd0) begin
                seen++;
                chk(n == TA + TC + TX - 1, "R6", "write done cycle", n, TA + TC + TX - 1);
            end
            if (which ? v1 : v0) rseen++;
            if (n == TA + TC + TX - 1)
                chk((which ? rdy1 : rdy0) == 1'b0, "R4", "busy in write", 1, 0);
        end
        chk((which ? rdy1 : rdy0) == 1'b1, "R6", "ready after write", 0, 1);
        chk(seen == 1, "R6", "write done count", seen, 1);
        chk(rseen == 0, "R8", "read strobe during write", rseen, 0);
        model[a] = d;
    endtask

    task automatic do_read(input int which, input int a, input bit poke);
        int got = 0, wseen = 0, total, line;
        total = exp_cycle(which, 3) + 1;
        line = a & ~3;
        @(negedge clk);
        chk((which ? rdy1 : rdy0) == 1'b1, "R4", "ready before read", 0, 1);
        req_v[which] = 1'b1; req_wr = 1'b0; req_a = AW'(a);
        @(posedge clk);
        for (int n = 0; n <= total; n++) begin
            @(negedge clk);
            if (n == 0) req_v[which] = 1'b0;
            if (poke && n == 5) begin
                req_v[which] = 1'b1; req_wr = 1'b1; req_a = AW'(line + 1); req_d = 32'hDEAD_BEEF;
            end
            if (poke && n == 7) begin
                req_v[which] = 1'b0; req_wr = 1'b0; req_a = AW'(a);
            end
            if (which ? wd1 : wd0) wseen++;
            if (which ? v1 : v0) begin
                chk(n == exp_cycle(which, got), which ? "R5" : "R2", "word valid cycle",
                    n, exp_cycle(which, got));
                chk((which ? w1 : w0) == 2'(got), "R3", "word order", which ? w1 : w0, got);
                chk((which ? d1 : d0) == model[line + got], "R7", "word data",
                    which ? d1 : d0, model[line + got]);
                got++;
            end
            if (n == total - 1)
                chk((which ? rdy1 : rdy0) == 1'b0, "R4", "busy at last word", 1, 0);
        end
        chk((which ? rdy1 : rdy0) == 1'b1, which ? "R5" : "R4", "ready after line", 0, 1);
        chk(got == 4, "R3", "words per line", got, 4);
        chk(wseen == 0, "R8", "write strobe during read", wseen, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NW; i++) model[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(rdy0 && rdy1, "R1", "ready in reset", rdy0 & rdy1, 1);
        chk(!v0 && !v1 && !wd0 && !wd1, "R1", "strobes in reset", v0 | v1 | wd0 | wd1, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rdy0 && rdy1 && !v0 && !wd0, "R1", "idle after reset", rdy0 & rdy1, 1);

        // fill every word in both controllers
        for (int a = 0; a < NW; a++) begin
            logic [DW-1:0] d = $urandom;
            do_write(0, a, d);
            do_write(1, a, d);
        end
        do_read(0, 0, 1'b0);
        do_read(1, 0, 1'b0);
        do_read(0, NW - 1, 1'b0);   // R7: low bits 3 still returns whole line
        do_read(1, 4 * 9 + 2, 1'b0);
        // R4: busy poke must not store nor disturb timing
        do_read(0, 20, 1'b1);
        do_read(0, 20, 1'b0);
        do_read(1, 40, 1'b1);
        do_read(1, 40, 1'b0);
        // R6: one store leaves its neighbours intact
        do_write(0, 4 * 5 + 2, 32'h1234_5678);
        do_read(0, 4 * 5, 1'b0);
        do_write(1, 4 * 5 + 2, 32'h1234_5678);
        do_read(1, 4 * 5 + 3, 1'b0);
        for (int it = 0; it < 40; it++) begin
            int a = int'($urandom % NW);
            if ($urandom % 2) begin
                logic [DW-1:0] d = $urandom;
                do_write(0, a, d);
                do_write(1, a, d);
            end else begin
                do_read(int'($urandom % 2), a, 1'b0);
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule